// File: doc/BRIEF.md
# Hard-Sectored Track Format Write Sequencer

This block produces the byte stream that lays down one sector of a hard-sectored track while a track is being formatted, and it drives the write gate and address-mark-enable controls that go with it. Each sector pulse restarts the sequence. The sequence is the trailing part of the intersector gap, a zero sync run, the sync pattern, five header bytes, the header check bytes and their pad, a write splice, a second sync run with its pattern, the data field, the data check bytes and their pad, and the speed-tolerance gap. The last item is the leading part of the next intersector gap. After that the block emits zeros until the next sector pulse. It emits one byte per clock into a downstream serializer.

Header content comes in on a parallel port. Data bytes and check bytes are pulled from upstream sources over valid/ready handshakes. The check-code arithmetic is done upstream. If a source stalls while the sequencer is pulling from it, the sequencer flags an underrun and fills the rest of that field with zeros. Every field length is a parameter. The defaults give the minimum layout plus a short data field.

Top module: `fmt_sector_writer`

## Requirements
- R1: While reset is held and after it is released, before any sector pulse: writeGate, wrValid, addrMarkEn, underrun, dataReady and chkReady are all 0.
- R2: The stream order after a sector pulse is: gap (GAP_AFTER zeros), sync run, pattern, 5 header bytes, CHK_LEN check bytes, PAD_LEN zeros, SPLICE_LEN zeros, sync run, pattern, DATA_LEN data bytes, CHK_LEN check bytes, PAD_LEN zeros, TOL_LEN zeros, GAP_BEFORE zeros. Exactly DATA_LEN data bytes and 2*CHK_LEN check bytes are accepted per sector, and the two readies are never high together.
- R3: Each sync run is SYNC_LEN zero bytes and is followed by one SYNC_PAT byte (default 8'hFE).
- R4: The header bytes are emitted in the order hdrAddr[39:32] (flag/unit), [31:24] (cylinder high), [23:16] (cylinder low), [15:8] (head), [7:0] (sector).
- R5: addrMarkEn is high during the GAP_AFTER gap bytes that follow a sector pulse. It falls in the same cycle as the first header sync byte, while writeGate stays high.
- R6: The first gap byte appears on wrByte two clocks after the clock edge that samples sectorPulse. wrValid and writeGate stay high on every byte of the sector.
- R7: After the GAP_BEFORE bytes, the block keeps emitting zero bytes with writeGate high until the next sector pulse.
- R8: A sector pulse that arrives in the middle of a sector restarts the stream at the first gap byte, and writeGate does not drop.
- R9: If the data source is not valid while the data field is being pulled, underrun goes high in the same cycle that a zero byte is emitted in place of the data. The rest of the field is zeros, and dataReady stays low until the field ends.
- R10: A sector pulse clears underrun.
- R11: A sector pulse with fmtEn low stops the stream. writeGate and wrValid go low two clocks after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmtEn | input | 1 | Format enable, sampled at each sector pulse |
| sectorPulse | input | 1 | Sector pulse, one clock wide |
| hdrAddr | input | 40 | Header bytes: flag, cylinder high, cylinder low, head, sector |
| dataByte | input | 8 | Data field byte from the data source |
| dataValid | input | 1 | Data source has a byte |
| dataReady | output | 1 | Sequencer takes the data byte this clock |
| chkByte | input | 8 | Check byte from the check source |
| chkValid | input | 1 | Check source has a byte |
| chkReady | output | 1 | Sequencer takes the check byte this clock |
| wrByte | output | 8 | Byte to be written |
| wrValid | output | 1 | wrByte carries a sector byte |
| writeGate | output | 1 | Write gate to the drive |
| addrMarkEn | output | 1 | Address mark enable; its falling edge marks the header sync start |
| underrun | output | 1 | A handshake source stalled during its field in this sector |

## Verification
If the segment state or its byte counter goes wrong, the stream shows it at once. A field boundary that is off by one moves the FEh pattern, the header bytes and the falling edge of addrMarkEn by one byte. It also changes how many data and check bytes get accepted. All of this is visible within the sector where the error occurs. A wrong starve or underrun state shows up in the first cycle after a stall, either as a non-zero data byte or as a ready that is still asserted. A restart path that is broken shows up two clocks after the pulse, when the gap byte, addrMarkEn or writeGate is wrong.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_GAPA, ST_SYNCH, ST_PATH, ST_ADDR, ST_ACHK, ST_APAD, ST_SPLICE,
    ST_SYNCD, ST_PATD, ST_DATA, ST_DCHK, ST_DPAD, ST_TOL, ST_GAPB, ST_WAIT
  } seg_e;

  typedef enum logic [2:0] {SRC_ZERO, SRC_PAT, SRC_ADDR, SRC_CHK, SRC_DATA} src_e;

  typedef struct packed {
    logic       active;
    logic       ame;
    src_e       src;
    logic [2:0] addrIdx;
    logic       fault;
    logic       clrFault;
  } strobe_t;

  localparam int ADDR_LEN = 5;
endpackage

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
  import fsw_pkg::*;
#(
  parameter int GAP_AFTER  = 12,
  parameter int GAP_BEFORE = 4,
  parameter int SYNC_LEN   = 11,
  parameter int CHK_LEN    = 2,
  parameter int PAD_LEN    = 2,
  parameter int SPLICE_LEN = 1,
  parameter int DATA_LEN   = 16,
  parameter int TOL_LEN    = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fmtEn,
  input  logic    sectorPulse,
  input  logic    dataValid,
  input  logic    chkValid,
  output logic    dataReady,
  output logic    chkReady,
  output strobe_t stb
);
  localparam int MAXLEN = GAP_AFTER + GAP_BEFORE + SYNC_LEN + CHK_LEN + PAD_LEN
                        + SPLICE_LEN + DATA_LEN + TOL_LEN + ADDR_LEN;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  seg_e             seg;
  logic [CNT_W-1:0] cnt;
  logic             starve;
  logic             lastByte;
  logic             inChk;

  function automatic int segLen(seg_e s);
    case (s)
      ST_GAPA:            return GAP_AFTER;
      ST_SYNCH, ST_SYNCD: return SYNC_LEN;
      ST_ADDR:            return ADDR_LEN;
      ST_ACHK, ST_DCHK:   return CHK_LEN;
      ST_APAD, ST_DPAD:   return PAD_LEN;
      ST_SPLICE:          return SPLICE_LEN;
      ST_DATA:            return DATA_LEN;
      ST_TOL:             return TOL_LEN;
      ST_GAPB:            return GAP_BEFORE;
      default:            return 1;
    endcase
  endfunction

  function automatic seg_e segNext(seg_e s);
    case (s)
      ST_GAPA:   return ST_SYNCH;
      ST_SYNCH:  return ST_PATH;
      ST_PATH:   return ST_ADDR;
      ST_ADDR:   return ST_ACHK;
      ST_ACHK:   return ST_APAD;
      ST_APAD:   return ST_SPLICE;
      ST_SPLICE: return ST_SYNCD;
      ST_SYNCD:  return ST_PATD;
      ST_PATD:   return ST_DATA;
      ST_DATA:   return ST_DCHK;
      ST_DCHK:   return ST_DPAD;
      ST_DPAD:   return ST_TOL;
      ST_TOL:    return ST_GAPB;
      ST_GAPB:   return ST_WAIT;
      default:   return s;
    endcase
  endfunction

  assign lastByte  = (cnt == CNT_W'(segLen(seg) - 1));
  assign inChk     = (seg == ST_ACHK) || (seg == ST_DCHK);
  assign dataReady = (seg == ST_DATA) && !starve;
  assign chkReady  = inChk && !starve;

  always_comb begin
    stb          = '0;
    stb.active   = (seg != ST_IDLE);
    stb.ame      = (seg == ST_GAPA);
    stb.addrIdx  = cnt[2:0];
    stb.clrFault = sectorPulse;
    stb.fault    = (dataReady && !dataValid) || (chkReady && !chkValid);
    case (seg)
      ST_PATH, ST_PATD: stb.src = SRC_PAT;
      ST_ADDR:          stb.src = SRC_ADDR;
      ST_ACHK, ST_DCHK: stb.src = starve ? SRC_ZERO : SRC_CHK;
      ST_DATA:          stb.src = starve ? SRC_ZERO : SRC_DATA;
      default:          stb.src = SRC_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg    <= ST_IDLE;
      cnt    <= '0;
      starve <= 1'b0;
    end else if (sectorPulse) begin
      seg    <= fmtEn ? ST_GAPA : ST_IDLE;
      cnt    <= '0;
      starve <= 1'b0;
    end else if (seg != ST_IDLE && seg != ST_WAIT) begin
      if (lastByte) begin
        seg    <= segNext(seg);
        cnt    <= '0;
        starve <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (stb.fault) starve <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsw_datapath.sv
module fsw_datapath
  import fsw_pkg::*;
#(
  parameter logic [7:0] SYNC_PAT = 8'hFE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               stb,
  input  logic [ADDR_LEN*8-1:0] hdrAddr,
  input  logic [7:0]            dataByte,
  input  logic                  dataValid,
  input  logic [7:0]            chkByte,
  input  logic                  chkValid,
  output logic [7:0]            wrByte,
  output logic                  wrValid,
  output logic                  writeGate,
  output logic                  addrMarkEn,
  output logic                  underrun
);
  logic [7:0] nextByte;
  logic [7:0] hdrBytes [ADDR_LEN];

  for (genvar g = 0; g < ADDR_LEN; g++) begin : g_hdr
    assign hdrBytes[g] = hdrAddr[(ADDR_LEN-g)*8-1 -: 8];
  end

  always_comb begin
    case (stb.src)
      SRC_PAT:  nextByte = SYNC_PAT;
      SRC_ADDR: nextByte = (int'(stb.addrIdx) < ADDR_LEN) ? hdrBytes[stb.addrIdx] : 8'h00;
      SRC_CHK:  nextByte = chkValid ? chkByte : 8'h00;
      SRC_DATA: nextByte = dataValid ? dataByte : 8'h00;
      default:  nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrByte     <= '0;
      wrValid    <= 1'b0;
      writeGate  <= 1'b0;
      addrMarkEn <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      wrByte     <= nextByte;
      wrValid    <= stb.active;
      writeGate  <= stb.active;
      addrMarkEn <= stb.ame;
      if (stb.clrFault)   underrun <= 1'b0;
      else if (stb.fault) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/fmt_sector_writer.sv
module fmt_sector_writer
  import fsw_pkg::*;
#(
  parameter int         GAP_AFTER  = 12,
  parameter int         GAP_BEFORE = 4,
  parameter int         SYNC_LEN   = 11,
  parameter int         CHK_LEN    = 2,
  parameter int         PAD_LEN    = 2,
  parameter int         SPLICE_LEN = 1,
  parameter int         DATA_LEN   = 16,
  parameter int         TOL_LEN    = 3,
  parameter logic [7:0] SYNC_PAT   = 8'hFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmtEn,
  input  logic        sectorPulse,
  input  logic [39:0] hdrAddr,
  input  logic [7:0]  dataByte,
  input  logic        dataValid,
  output logic        dataReady,
  input  logic [7:0]  chkByte,
  input  logic        chkValid,
  output logic        chkReady,
  output logic [7:0]  wrByte,
  output logic        wrValid,
  output logic        writeGate,
  output logic        addrMarkEn,
  output logic        underrun
);
  strobe_t stb;

  fsw_ctrl #(
    .GAP_AFTER(GAP_AFTER), .GAP_BEFORE(GAP_BEFORE), .SYNC_LEN(SYNC_LEN),
    .CHK_LEN(CHK_LEN), .PAD_LEN(PAD_LEN), .SPLICE_LEN(SPLICE_LEN),
    .DATA_LEN(DATA_LEN), .TOL_LEN(TOL_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fmtEn(fmtEn), .sectorPulse(sectorPulse),
    .dataValid(dataValid), .chkValid(chkValid),
    .dataReady(dataReady), .chkReady(chkReady), .stb(stb)
  );

  fsw_datapath #(.SYNC_PAT(SYNC_PAT)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .hdrAddr(hdrAddr),
    .dataByte(dataByte), .dataValid(dataValid),
    .chkByte(chkByte), .chkValid(chkValid),
    .wrByte(wrByte), .wrValid(wrValid), .writeGate(writeGate),
    .addrMarkEn(addrMarkEn), .underrun(underrun)
  );
endmodule

// File: rtl/fmt_sector_writer_chk.sv
module fmt_sector_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fmtEn,
  input logic        sectorPulse,
  input logic [39:0] hdrAddr,
  input logic [7:0]  dataByte,
  input logic        dataValid,
  input logic        dataReady,
  input logic [7:0]  chkByte,
  input logic        chkValid,
  input logic        chkReady,
  input logic [7:0]  wrByte,
  input logic        wrValid,
  input logic        writeGate,
  input logic        addrMarkEn,
  input logic        underrun
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dataReady && chkReady)); // R2

  AST_AME_NEEDS_WG: assert property (@(posedge clk) disable iff (!rst_n)
    addrMarkEn |-> writeGate); // R5

  AST_AME_FALL_WG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addrMarkEn) |-> writeGate); // R5

  AST_START_AME: assert property (@(posedge clk) disable iff (!rst_n)
    (sectorPulse && fmtEn) |=> ##1 (addrMarkEn && writeGate && wrByte == 8'h00)); // R6

  AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dataReady && !dataValid && !sectorPulse) |=> (underrun && wrByte == 8'h00)); // R9

  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sectorPulse |=> !underrun); // R10

  AST_STOP_DROPS_WG: assert property (@(posedge clk) disable iff (!rst_n)
    (sectorPulse && !fmtEn) |=> ##1 (!writeGate && !wrValid)); // R11
endmodule

bind fmt_sector_writer fmt_sector_writer_chk u_chk (.*);

// File: tb/fmt_sector_writer_test.sv
module fmt_sector_writer_test;
  localparam int GA = 12, GB = 4, SY = 11, CK = 2, PD = 2, SP = 1, DL = 16, TL = 3;
  localparam int DATA_OFF = GA + SY + 1 + 5 + CK + PD + SP + SY + 1;
  localparam int SECT = DATA_OFF + DL + CK + PD + TL + GB;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        fmtEn = 0;
  logic        sectorPulse = 0;
  logic [39:0] hdrAddr = 40'h11_22_33_44_55;
  logic [7:0]  dataByte, chkByte;
  logic        dataValid, chkValid;
  logic        dataReady, chkReady;
  logic [7:0]  wrByte;
  logic        wrValid, writeGate, addrMarkEn, underrun;

  int  dataCnt = 0, chkCnt = 0;
  bit  feedOn = 1, stallOn = 0;
  int  stallAt = 0;
  int  nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  assign dataValid = feedOn && !(stallOn && dataCnt == stallAt);
  assign dataByte  = 8'h40 + dataCnt[7:0];
  assign chkValid  = 1'b1;
  assign chkByte   = 8'hA0 + chkCnt[7:0];

  always @(posedge clk) begin
    if (dataValid && dataReady) dataCnt <= dataCnt + 1;
    if (chkValid && chkReady)   chkCnt  <= chkCnt + 1;
  end

  fmt_sector_writer uut (
    .clk(clk), .rst_n(rst_n), .fmtEn(fmtEn), .sectorPulse(sectorPulse),
    .hdrAddr(hdrAddr), .dataByte(dataByte), .dataValid(dataValid),
    .dataReady(dataReady), .chkByte(chkByte), .chkValid(chkValid),
    .chkReady(chkReady), .wrByte(wrByte), .wrValid(wrValid),
    .writeGate(writeGate), .addrMarkEn(addrMarkEn), .underrun(underrun)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expByte(int i, int stall);
    int p = i;
    if (p < GA) return 0;            p -= GA;
    if (p < SY) return 0;            p -= SY;
    if (p < 1)  return 'hFE;         p -= 1;
    if (p < 5)  return int'(hdrAddr[39-8*p -: 8]); p -= 5;
    if (p < CK) return 'hA0 + p;     p -= CK;
    if (p < PD + SP + SY) return 0;  p -= PD + SP + SY;
    if (p < 1)  return 'hFE;         p -= 1;
    if (p < DL) return (p < stall) ? 'h40 + p : 0; p -= DL;
    if (p < CK) return 'hA0 + CK + p;
    return 0;
  endfunction

  task automatic pulse(bit en);
    @(negedge clk);
    fmtEn = en;
    sectorPulse = 1;
    @(posedge clk);
    @(negedge clk);
    sectorPulse = 0;
    dataCnt = 0;
    chkCnt = 0;
  endtask

  // Observe n bytes after a pulse; index 0 is the first gap byte.
  task automatic observe(int n, int stall, string req);
    int badB = -1, badA = -1, badG = -1, badU = -1;
    int actB = 0, expB = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (badB < 0 && int'(wrByte) != expByte(i, stall)) begin
        badB = i; actB = wrByte; expB = expByte(i, stall);
      end
      if (badA < 0 && addrMarkEn != (i < GA)) badA = i;
      if (badG < 0 && !(writeGate && wrValid)) badG = i;
      if (badU < 0 && underrun != (stall < DL && i >= DATA_OFF + stall)) badU = i;
    end
    check(badB < 0, req, $sformatf("stream byte %0d", badB), actB, expB);
    check(badA < 0, "R5", "addrMarkEn mismatch at byte", badA, -1);
    check(badG < 0, "R6", "gate/valid low at byte", badG, -1);
    check(badU < 0, "R9", "underrun mismatch at byte", badU, -1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!writeGate && !wrValid && !addrMarkEn && !underrun, "R1", "outputs in reset",
          {writeGate, wrValid, addrMarkEn, underrun}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!writeGate && !wrValid && !dataReady && !chkReady, "R1", "idle after reset",
          {writeGate, wrValid, dataReady, chkReady}, 0);
  endtask

  task automatic t_normal();
    pulse(1);
    check(!writeGate, "R6", "gate before first byte", writeGate, 0);
    observe(SECT + 6, DL, "R2 R3 R4 R7");
    check(dataCnt == DL, "R2", "data bytes accepted", dataCnt, DL);
    check(chkCnt == 2 * CK, "R2", "check bytes accepted", chkCnt, 2 * CK);
  endtask

  task automatic t_restart();
    hdrAddr = 40'hA5_0F_F0_3C_C3;
    pulse(1);
    observe(50, DL, "R8 first part");
    pulse(1);
    check(writeGate, "R8", "gate held over restart", writeGate, 1);
    observe(SECT, DL, "R8 restarted");
    check(dataCnt == DL, "R8", "data bytes after restart", dataCnt, DL);
  endtask

  task automatic t_underrun();
    stallOn = 1;
    stallAt = 5;
    pulse(1);
    observe(SECT, 5, "R9");
    check(dataCnt == 5, "R9", "no pulls after stall", dataCnt, 5);
    check(underrun, "R9", "underrun held", underrun, 1);
    stallOn = 0;
    pulse(1);
    check(!underrun, "R10", "underrun cleared by pulse", underrun, 0);
    observe(SECT, DL, "R10 clean sector");
  endtask

  task automatic t_stop();
    pulse(0);
    @(negedge clk);
    check(!writeGate && !wrValid && !addrMarkEn, "R11", "stop drops gate",
          {writeGate, wrValid, addrMarkEn}, 0);
    repeat (3) @(negedge clk);
    check(!dataReady && !chkReady && !writeGate, "R11", "stays stopped",
          {dataReady, chkReady, writeGate}, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_restart();
    t_underrun();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule